// File: doc/BRIEF.md
# Synchronous Buck Gate Control Logic

This block turns the digital command for one synchronous buck channel into two gate-drive enables: one for the high-side switch and one for the low-side switch. The command is a PWM level plus a separate pre-decoded indication that the PWM pin sits at its mid (tri-state) level. A synchronous-rectifier enable chooses whether the low-side switch conducts while PWM is low. Every input arrives already synchronised to the block clock.

A four-state machine owns the switches:

- `ST_IDLE`: both switches off, with no dead time pending.
- `ST_HS_ON`: the high-side switch conducts.
- `ST_LS_ON`: the low-side switch conducts.
- `ST_DEAD`: both switches off while a dead-time counter runs.

The transitions are:

- `IDLE→HS_ON` when the high side is wanted.
- `IDLE→LS_ON` when the low side is wanted.
- `IDLE→DEAD` on shutdown.
- `HS_ON→DEAD` on loss of demand, on overcurrent or on shutdown.
- `LS_ON→DEAD` on loss of demand or on shutdown.
- `DEAD→HS_ON`, `DEAD→LS_ON` or `DEAD→IDLE` once the counter is spent and shutdown is low, chosen by the current demand.

Because every turn-off passes through `ST_DEAD`, the two switches can never conduct together. The anti-cross-conduction gap is `DEAD_CYC` clock cycles.

An overcurrent input that arrives while the high side conducts ends the pulse at once. A truncation latch then blocks the high side until PWM has gone low and risen again. A shutdown input overrides every other input. The block also issues a one-clock cycle-start strobe on each rising edge of the effective PWM-high level, for use by the fault logic.

Top module: `buck_gate_ctrl`

## Requirements
- R1: With `pwm_hi`=1 and `pwm_mid`=0, no truncation pending and no dead time pending, `hs_en` is 1 and `ls_en` is 0 one clock after the command, whatever `sr_en` is.
- R2: With `pwm_hi`=0, `pwm_mid`=0 and `sr_en`=1, the steady outputs are `ls_en`=1 and `hs_en`=0.
- R3: With `pwm_hi`=0, `pwm_mid`=0 and `sr_en`=0, both enables are 0; `ls_en` is 0 on every clock that follows a sampled `sr_en`=0.
- R4: `pwm_mid`=1 overrides `pwm_hi` and `sr_en`: both enables are 0 from the next clock on.
- R5: `hs_en` and `ls_en` are never 1 in the same cycle. After either enable falls, both stay 0 for at least `DEAD_CYC` cycles. When the opposite demand is held, the other enable rises `DEAD_CYC`+1 clocks after the command change.
- R6: When `oc_trip` is 1 while `hs_en` is 1, `hs_en` is 0 from the next clock on and stays 0 until `pwm_hi` has been low and then high again. `oc_trip` has no effect while `hs_en` is 0.
- R7: When `shdn` is 1, both enables are 0 from the next clock on, whatever the other inputs are. After `shdn` is released with demand present, the first enable rises `DEAD_CYC` clocks after the release.
- R8: `cyc_start` is 1 for exactly one cycle, one clock after the effective PWM-high level (`pwm_hi`=1 and `pwm_mid`=0) changes from 0 to 1. It is 0 at all other times.
- R9: During and right after reset, `hs_en`, `ls_en` and `cyc_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_hi | input | 1 | PWM command at its high level |
| pwm_mid | input | 1 | PWM command at its mid (tri-state) level; dominates `pwm_hi` |
| sr_en | input | 1 | Synchronous-rectifier enable; allows the low side to conduct |
| oc_trip | input | 1 | High-side overcurrent comparator result |
| shdn | input | 1 | Shutdown; forces both switches off |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| cyc_start | output | 1 | One-clock strobe at each start of a PWM-high period |

## Verification
Each enable is a decode of the state register, so every command, overcurrent or shutdown result appears one clock after the edge that samples it, and `cyc_start` has the same one-clock latency. A switch-over between the two switches takes `DEAD_CYC`+1 clocks from the command change. A restart after shutdown takes `DEAD_CYC` clocks from the release.

The bench drives inputs on the falling edge and counts falling edges before it samples. It therefore checks the strobe one edge after the stimulus, both-low at each intermediate edge of a switch-over, and the enable at exactly the edge where it is due. The exhaustive sweep holds each input pattern well past `DEAD_CYC`+1 clocks before it checks the steady outputs.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HS_ON = 2'd1,
        ST_LS_ON = 2'd2,
        ST_DEAD  = 2'd3
    } gate_state_e;

endpackage

// File: rtl/buck_pwm_decode.sv
module buck_pwm_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi,
    input  logic pwm_mid,
    input  logic sr_en,
    input  logic oc_trip,
    input  logic hs_on,
    output logic want_hs,
    output logic want_ls,
    output logic cyc_start
);

    logic hi_lvl;
    logic hi_q;
    logic trunc_q;
    logic strobe_q;

    assign hi_lvl = pwm_hi & ~pwm_mid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= 1'b0;
            strobe_q <= 1'b0;
            trunc_q  <= 1'b0;
        end else begin
            hi_q     <= hi_lvl;
            strobe_q <= hi_lvl & ~hi_q;
            if (!hi_lvl) begin
                trunc_q <= 1'b0;
            end else if (hs_on && oc_trip) begin
                trunc_q <= 1'b1;
            end
        end
    end

    assign want_hs   = hi_lvl & ~trunc_q;
    assign want_ls   = ~pwm_hi & ~pwm_mid & sr_en;
    assign cyc_start = strobe_q;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |=> !strobe_q); // R8

    AST_TRUNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (trunc_q && hi_lvl) |=> trunc_q); // R6

endmodule

// File: rtl/buck_dead_timer.sv
module buck_dead_timer #(
    parameter int DEAD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);

    localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    AST_DEAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RELOAD); // R5

endmodule

// File: rtl/buck_gate_ctrl.sv
module buck_gate_ctrl
    import buck_gate_pkg::*;
#(
    parameter int DEAD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi,
    input  logic pwm_mid,
    input  logic sr_en,
    input  logic oc_trip,
    input  logic shdn,
    output logic hs_en,
    output logic ls_en,
    output logic cyc_start
);

    gate_state_e state_q;
    gate_state_e state_d;
    logic want_hs;
    logic want_ls;
    logic dead_done;
    logic dead_load;
    logic hs_on;

    assign hs_on = (state_q == ST_HS_ON);

    buck_pwm_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_hi    (pwm_hi),
        .pwm_mid   (pwm_mid),
        .sr_en     (sr_en),
        .oc_trip   (oc_trip),
        .hs_on     (hs_on),
        .want_hs   (want_hs),
        .want_ls   (want_ls),
        .cyc_start (cyc_start)
    );

    buck_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dead_load),
        .done  (dead_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (shdn)         state_d = ST_DEAD;
                else if (want_hs) state_d = ST_HS_ON;
                else if (want_ls) state_d = ST_LS_ON;
            end
            ST_HS_ON: begin
                if (shdn || oc_trip || !want_hs) state_d = ST_DEAD;
            end
            ST_LS_ON: begin
                if (shdn || !want_ls) state_d = ST_DEAD;
            end
            ST_DEAD: begin
                if (!shdn && dead_done) begin
                    if (want_hs)      state_d = ST_HS_ON;
                    else if (want_ls) state_d = ST_LS_ON;
                    else              state_d = ST_IDLE;
                end
            end
            default: state_d = ST_DEAD;
        endcase
    end

    assign dead_load = (state_d == ST_DEAD) && ((state_q != ST_DEAD) || shdn);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        hs_en = 1'b0;
        ls_en = 1'b0;
        unique case (state_q)
            ST_HS_ON: hs_en = 1'b1;
            ST_LS_ON: ls_en = 1'b1;
            default: begin
                hs_en = 1'b0;
                ls_en = 1'b0;
            end
        endcase
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en)); // R5

    AST_SHDN_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> (!hs_en && !ls_en)); // R7

    AST_MID_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_mid |=> (!hs_en && !ls_en)); // R4

    AST_LS_NEEDS_SR: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_en |=> !ls_en); // R3

    AST_OC_CUTS_HS: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && oc_trip) |=> !hs_en); // R6

endmodule

// File: tb/buck_gate_ctrl_bench.sv
`timescale 1ns/1ps
module buck_gate_ctrl_bench;

    localparam int DT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_hi = 1'b0;
    logic pwm_mid = 1'b0;
    logic sr_en = 1'b0;
    logic oc_trip = 1'b0;
    logic shdn = 1'b0;
    logic hs_en;
    logic ls_en;
    logic cyc_start;

    int n_chk = 0;
    int n_fail = 0;
    int overlap = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    buck_gate_ctrl #(.DEAD_CYC(DT)) u_buck_gate_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_hi    (pwm_hi),
        .pwm_mid   (pwm_mid),
        .sr_en     (sr_en),
        .oc_trip   (oc_trip),
        .shdn      (shdn),
        .hs_en     (hs_en),
        .ls_en     (ls_en),
        .cyc_start (cyc_start)
    );

    always @(negedge clk) if (rst_n && hs_en && ls_en) overlap++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(4);
        chk("R9 hs in reset", hs_en, 1'b0);
        chk("R9 ls in reset", ls_en, 1'b0);
        chk("R9 strobe in reset", cyc_start, 1'b0);
        rst_n = 1'b1;
        tick(2);
        chk("R9 hs after reset", hs_en, 1'b0);
        chk("R9 ls after reset", ls_en, 1'b0);

        // R1 / R8: idle to high side
        pwm_hi = 1'b1;
        tick(1);
        chk("R1 hs on", hs_en, 1'b1);
        chk("R1 ls off", ls_en, 1'b0);
        chk("R8 strobe high", cyc_start, 1'b1);
        tick(1);
        chk("R8 strobe one cycle", cyc_start, 1'b0);

        // R5 / R2: high side to low side
        sr_en = 1'b1;
        pwm_hi = 1'b0;
        for (int j = 1; j <= DT; j++) begin
            tick(1);
            chk("R5 gap hs", hs_en, 1'b0);
            chk("R5 gap ls", ls_en, 1'b0);
        end
        tick(1);
        chk("R2 ls on after gap", ls_en, 1'b1);

        // R5: low side to high side
        pwm_hi = 1'b1;
        for (int j = 1; j <= DT; j++) begin
            tick(1);
            chk("R5 gap ls", ls_en, 1'b0);
            chk("R5 gap hs", hs_en, 1'b0);
        end
        tick(1);
        chk("R5 hs on after gap", hs_en, 1'b1);

        // R6: overcurrent truncation
        oc_trip = 1'b1;
        tick(1);
        oc_trip = 1'b0;
        chk("R6 hs cut", hs_en, 1'b0);
        tick(10);
        chk("R6 hs stays cut", hs_en, 1'b0);
        chk("R6 ls stays off", ls_en, 1'b0);
        pwm_hi = 1'b0;
        tick(DT + 1);
        chk("R6 ls after pwm low", ls_en, 1'b1);
        pwm_hi = 1'b1;
        tick(DT + 1);
        chk("R6 hs rearmed", hs_en, 1'b1);

        // R6: overcurrent ignored while high side off
        pwm_hi = 1'b0;
        tick(DT + 1);
        oc_trip = 1'b1;
        tick(1);
        oc_trip = 1'b0;
        chk("R6 oc ignored ls", ls_en, 1'b1);
        chk("R6 oc ignored hs", hs_en, 1'b0);

        // R7: shutdown
        pwm_hi = 1'b1;
        tick(DT + 1);
        chk("R7 hs before shdn", hs_en, 1'b1);
        shdn = 1'b1;
        tick(1);
        chk("R7 hs off", hs_en, 1'b0);
        chk("R7 ls off", ls_en, 1'b0);
        pwm_hi = 1'b0;
        tick(5);
        chk("R7 override ls", ls_en, 1'b0);
        pwm_hi = 1'b1;
        shdn = 1'b0;
        tick(DT - 1);
        chk("R7 still off", hs_en, 1'b0);
        tick(1);
        chk("R7 resume", hs_en, 1'b1);

        // Exhaustive sweep over {pwm_hi, pwm_mid, sr_en}: R1 R2 R3 R4 R8
        for (int p = 0; p < 8; p++) begin
            for (int n = 0; n < 8; n++) begin
                logic hp;
                logic hn;
                hp = p[2] & ~p[1];
                hn = n[2] & ~n[1];
                {pwm_hi, pwm_mid, sr_en} = 3'(p);
                tick(2 * DT + 6);
                {pwm_hi, pwm_mid, sr_en} = 3'(n);
                tick(1);
                chk("R8 sweep strobe", cyc_start, hn & ~hp);
                if (n[1]) begin
                    chk("R4 mid hs", hs_en, 1'b0);
                    chk("R4 mid ls", ls_en, 1'b0);
                end
                tick(2 * DT + 4);
                chk("R1 sweep hs", hs_en, hn);
                chk("R2 R3 sweep ls", ls_en, ~n[2] & ~n[1] & n[0]);
            end
        end

        chk("R5 no overlap", (overlap == 0), 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule